// File: doc/BRIEF.md
# Packed Instruction Fetch Queue

This block is the fetch front end of a 32-bit stack processor whose code and data live in one shared memory. It reads one 32-bit program word at a time through a valid/ready request channel and turns each word into issued instructions. A word with bit 31 clear packs five 6-bit short opcodes. They are handed out one per accepted issue handshake, starting from the most significant field. A word with bit 31 set is one long instruction: a jump or call with a 24-bit target. It is issued in a single handshake.

Literal opcodes have no operand bits of their own. Each one reads a full 32-bit value from the memory words that follow the packed word. The first literal uses the next word, the second uses the word after that, and so on. Once a packed word is finished, fetching continues just past its last operand word. The execute stage can redirect fetch at any cycle, for example for a taken branch, a call or a return. A redirect drops every slot not yet issued and discards the response to any read still in flight.

Back-pressure rules: the issue port presents an instruction with `iss_valid` and keeps every issue field unchanged until `iss_ready` is seen high. The request channel keeps `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready` is seen high. Responses carry no ready signal. The memory must return exactly one `mem_rsp_valid` pulse per accepted request, no earlier than the cycle after the request is accepted, and in order.

Top module: `pkq_fetch`

## Requirements
- R1: While reset is asserted, `iss_valid` is low. The first instruction fetch after reset requests address RESET_PC (default 0).
- R2: For a word with bit 31 = 0, the opcode slots are taken from bits [31:26], [25:20], [19:14], [13:8] and [7:2], in that order, one per accepted handshake. Bits [1:0] have no effect. Because bit 31 is the format bit, the first slot can only hold codes below 32.
- R3: An opcode value of 0 is never issued. When the next slot is 0, the rest of the word is dropped and the next instruction word is fetched.
- R4: For a word with bit 31 = 1, exactly one instruction is issued with `iss_long` = 1, `iss_call` = bit 30, `iss_opcode` = bits [29:24] and `iss_target` = bits [23:0]. The next word fetched is that word's address + 1.
- R5: A slot holding the literal code (default 1) fetches its operand from the word address + 1 + (number of earlier literals in the same word). `iss_valid` stays low until that operand arrives. The operand is then issued with `iss_lit` = 1, `iss_opcode` = the literal code and `iss_lit_value` = the operand. An operand word is never decoded as an instruction.
- R6: After a packed word at address A that used k literals, the next instruction word fetched is A + 1 + k.
- R7: While `redir_valid` is high, no issue handshake takes effect. In the next cycle `iss_valid` is low, and the next instruction fetch is at `redir_addr`. A response to a request accepted before or during the redirect cycle is discarded.
- R8: While `iss_valid` is high and `iss_ready` is low, with no redirect, all issue outputs hold their values into the next cycle.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, with no redirect, the request and its address hold into the next cycle.
- R10: At most one memory request is outstanding. No new request is made until the previous response has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 24 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per request) |
| mem_rsp_data | input | 32 | Read data |
| iss_valid | output | 1 | An instruction is presented |
| iss_ready | input | 1 | Execute stage accepts it |
| iss_opcode | output | 6 | Short opcode, or long sub-opcode when `iss_long` is high |
| iss_lit | output | 1 | Presented item is a literal |
| iss_lit_value | output | 32 | Literal operand, meaningful with `iss_lit` |
| iss_long | output | 1 | Presented item is a long jump or call |
| iss_call | output | 1 | Long item is a call |
| iss_target | output | 24 | Long target, meaningful with `iss_long` |
| redir_valid | input | 1 | Redirect from the execute stage |
| redir_addr | input | 24 | New instruction address |

## Verification
The program in the bench mixes a full word of five opcodes with the low bits set, a word ended early by a zero opcode, a long call, and a word holding three literals with a short opcode between two of them. Among the literal operand words is one with bit 31 set. This set separates slot order from bit position and shows whether operand words are ever decoded. It also shows whether the resume address counts the literals used. Two redirects are tried: one arrives while a packed word still has slots, and one arrives while a sequential fetch is in flight. These show apart slot flushing and stale-response dropping. Ready is stalled on both channels in irregular patterns, and memory latency varies, so every hold rule is exercised.

// File: rtl/pkq_pkg.sv
package pkq_pkg;
  typedef enum logic [2:0] {
    ST_FETCH,    // instruction word wanted
    ST_WAITW,    // instruction word in flight
    ST_RUN,      // handing out packed slots
    ST_LITWAIT,  // literal operand in flight
    ST_LITOUT,   // literal operand presented
    ST_LONG      // long instruction presented
  } fq_state_e;
endpackage

// File: rtl/pkq_mem_port.sv
module pkq_mem_port #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic [ADDR_W-1:0] want_addr,
  input  logic              flush,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              rsp_take
);
  logic inflight_q, drop_q, fire;

  assign req_valid = want && !inflight_q;
  assign req_addr  = want_addr;
  assign fire      = req_valid && req_ready;
  // a response is useful only if nothing redirected fetch since its request
  assign rsp_take  = rsp_valid && inflight_q && !drop_q && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      if (fire)           inflight_q <= 1'b1;
      else if (rsp_valid) inflight_q <= 1'b0;

      if (flush && ((inflight_q && !rsp_valid) || fire)) drop_q <= 1'b1;
      else if (rsp_valid)                                drop_q <= 1'b0;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !flush |=> req_valid && $stable(req_addr));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
endmodule

// File: rtl/pkq_slots.sv
module pkq_slots #(
  parameter int OP_W  = 6,
  parameter int SLOTS = 5,
  localparam int SLOT_BITS = OP_W * SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [SLOT_BITS-1:0] load_bits,
  input  logic                 shift,
  output logic [OP_W-1:0]      head
);
  logic [SLOT_BITS-1:0] q;
  logic [OP_W-1:0]      field [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_field
    assign field[i] = q[SLOT_BITS-1-i*OP_W -: OP_W];
  end

  assign head = field[0];

  // zeros enter from the bottom, so an exhausted word reads as a no-op
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_bits;
    else if (shift) q <= {q[SLOT_BITS-OP_W-1:0], {OP_W{1'b0}}};
  end

  p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift && !load |=> head == $past(field[1]));
endmodule

// File: rtl/pkq_fetch.sv
module pkq_fetch #(
  parameter int              ADDR_W   = 24,
  parameter int              WORD_W   = 32,
  parameter int              OP_W     = 6,
  parameter int              SLOTS    = 5,
  parameter logic [OP_W-1:0] LIT_CODE = 6'd1,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OP_W-1:0]   iss_opcode,
  output logic              iss_lit,
  output logic [WORD_W-1:0] iss_lit_value,
  output logic              iss_long,
  output logic              iss_call,
  output logic [ADDR_W-1:0] iss_target,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr
);
  import pkq_pkg::*;

  localparam int SLOT_BITS = OP_W * SLOTS;
  localparam int CNT_W     = $clog2(SLOTS + 1);
  localparam int FMT_BIT   = WORD_W - 1;
  localparam int CALL_BIT  = WORD_W - 2;
  localparam int LOP_TOP   = WORD_W - 3;

  fq_state_e           state_q;
  logic [ADDR_W-1:0]   pc_q, waddr_q, lit_addr, want_addr;
  logic [CNT_W-1:0]    lits_q;
  logic [WORD_W-1:0]   lit_val_q;
  logic [WORD_W-2:0]   long_q;
  logic [OP_W-1:0]     head;
  logic                head_lit, want, rsp_take, accept, load, shift, fire;

  assign head_lit  = (head == LIT_CODE);
  assign lit_addr  = waddr_q + ADDR_W'(1) + ADDR_W'(lits_q);
  assign want      = (state_q == ST_FETCH) || (state_q == ST_RUN && head_lit);
  assign want_addr = (state_q == ST_FETCH) ? pc_q : lit_addr;
  assign fire      = mem_req_valid && mem_req_ready;

  pkq_mem_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .want(want), .want_addr(want_addr),
    .flush(redir_valid), .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
    .req_valid(mem_req_valid), .req_addr(mem_req_addr), .rsp_take(rsp_take)
  );

  assign load  = rsp_take && (state_q == ST_WAITW) && !mem_rsp_data[FMT_BIT];
  assign shift = accept && (state_q == ST_RUN || state_q == ST_LITOUT);

  pkq_slots #(.OP_W(OP_W), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_bits(mem_rsp_data[WORD_W-1 -: SLOT_BITS]), .shift(shift), .head(head)
  );

  assign iss_valid     = (state_q == ST_RUN && head != '0 && !head_lit) ||
                         (state_q == ST_LITOUT) || (state_q == ST_LONG);
  assign iss_lit       = (state_q == ST_LITOUT);
  assign iss_long      = (state_q == ST_LONG);
  assign iss_opcode    = iss_long ? long_q[LOP_TOP -: OP_W] : head;
  assign iss_call      = iss_long && long_q[CALL_BIT];
  assign iss_target    = long_q[ADDR_W-1:0];
  assign iss_lit_value = lit_val_q;
  assign accept        = iss_valid && iss_ready && !redir_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FETCH;
      pc_q      <= RESET_PC;
      waddr_q   <= '0;
      lits_q    <= '0;
      lit_val_q <= '0;
      long_q    <= '0;
    end else if (redir_valid) begin
      state_q <= ST_FETCH;
      pc_q    <= redir_addr;
    end else begin
      unique case (state_q)
        ST_FETCH: if (fire) begin
          waddr_q <= pc_q;
          state_q <= ST_WAITW;
        end
        ST_WAITW: if (rsp_take) begin
          lits_q <= '0;
          if (mem_rsp_data[FMT_BIT]) begin
            long_q  <= mem_rsp_data[WORD_W-2:0];
            state_q <= ST_LONG;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (head == '0) begin
            pc_q    <= lit_addr;   // skips every operand word consumed
            state_q <= ST_FETCH;
          end else if (head_lit && fire) begin
            state_q <= ST_LITWAIT;
          end
        end
        ST_LITWAIT: if (rsp_take) begin
          lit_val_q <= mem_rsp_data;
          state_q   <= ST_LITOUT;
        end
        ST_LITOUT: if (accept) begin
          lits_q  <= lits_q + CNT_W'(1);
          state_q <= ST_RUN;
        end
        ST_LONG: if (accept) begin
          pc_q    <= waddr_q + ADDR_W'(1);
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  p_issue_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !redir_valid |=> iss_valid && $stable(iss_opcode) &&
    $stable(iss_lit) && $stable(iss_long) && $stable(iss_lit_value) && $stable(iss_target));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !iss_valid);

  p_lit_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_lit |-> iss_valid && !iss_long && iss_opcode == LIT_CODE);

  p_no_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_long |-> iss_opcode != '0);

  p_call_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_call |-> iss_long && iss_valid);
endmodule

// File: tb/tb_pkq_fetch.sv
module tb_pkq_fetch;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_rsp_data;
  logic          iss_valid, iss_ready, iss_lit, iss_long, iss_call;
  logic [5:0]    iss_opcode;
  logic [31:0]   iss_lit_value;
  logic [AW-1:0] iss_target;
  logic          redir_valid;
  logic [AW-1:0] redir_addr;

  pkq_fetch dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_opcode(iss_opcode),
    .iss_lit(iss_lit), .iss_lit_value(iss_lit_value), .iss_long(iss_long),
    .iss_call(iss_call), .iss_target(iss_target),
    .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  typedef struct packed {
    logic lit; logic lng; logic call; logic [5:0] op; logic [23:0] tgt; logic [31:0] val;
  } item_t;

  logic [31:0]   mem [0:127];
  item_t         exp_q[$];
  logic [AW-1:0] fetch_q[$];
  int            checks = 0, fails = 0, cyc = 0;
  string         tag = "R1";
  bit            pend = 0;
  logic [AW-1:0] paddr;
  int            pdelay;
  bit            h_valid = 0, rh_valid = 0, do_redir = 0;
  item_t         h_item;
  logic [AW-1:0] rh_addr, do_addr;

  function automatic logic [31:0] pack5(input logic [5:0] a, b, c, d, e, input logic [1:0] lo);
    return {a, b, c, d, e, lo};
  endfunction

  function automatic logic [31:0] longw(input logic call, input logic [5:0] op, input logic [23:0] t);
    return {1'b1, call, op, t};
  endfunction

  function automatic item_t cur_item();
    return '{lit: iss_lit, lng: iss_long, call: iss_call, op: iss_opcode,
             tgt: iss_target, val: iss_lit_value};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic short_op(input logic [5:0] op);
    exp_q.push_back('{lit: 0, lng: 0, call: 0, op: op, tgt: '0, val: '0});
  endtask

  task automatic lit_op(input logic [31:0] v);
    exp_q.push_back('{lit: 1, lng: 0, call: 0, op: 6'd1, tgt: '0, val: v});
  endtask

  // one cycle: drive inputs at the falling edge and judge the coming rising edge
  task automatic step();
    item_t a, e;
    logic [AW-1:0] fa;
    bit ok;
    @(negedge clk);
    cyc++;
    if (h_valid) check(iss_valid && cur_item() == h_item, "R8", "issue not held",
                       cur_item(), h_item);
    if (rh_valid) check(mem_req_valid && mem_req_addr == rh_addr, "R9", "request not held",
                        mem_req_addr, rh_addr);
    redir_valid = do_redir;
    redir_addr  = do_addr;
    if (pend && pdelay == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[paddr[6:0]];
      pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hx;
      if (pend) pdelay--;
    end
    mem_req_ready = (cyc % 4) != 1;
    iss_ready     = (cyc % 5) != 2;
    if (mem_req_valid && mem_req_ready) begin
      check(!pend, "R10", "request while one outstanding", mem_req_addr, paddr);
      if (fetch_q.size() > 0) begin
        fa = fetch_q.pop_front();
        check(mem_req_addr == fa, tag, "fetch address", mem_req_addr, fa);
      end
      pend = 1; paddr = mem_req_addr; pdelay = cyc % 3;
    end
    if (iss_valid && iss_ready && !redir_valid) begin
      a = cur_item();
      if (exp_q.size() == 0) begin
        check(0, tag, "unexpected issue", a, '0);
      end else begin
        e = exp_q.pop_front();
        ok = a.lit == e.lit && a.lng == e.lng && a.op == e.op;
        if (e.lng) ok = ok && a.call == e.call && a.tgt == e.tgt;
        if (e.lit) ok = ok && a.val == e.val;
        check(ok, tag, "issued item", a, e);
      end
    end
    h_valid  = iss_valid && !iss_ready && !redir_valid;
    h_item   = cur_item();
    rh_valid = mem_req_valid && !mem_req_ready && !redir_valid;
    rh_addr  = mem_req_addr;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() > 0 || fetch_q.size() > 0) begin
      step();
      n++;
      if (n > 3000) begin
        check(0, tag, "watchdog expired", exp_q.size(), 0);
        exp_q.delete();
        fetch_q.delete();
      end
    end
  endtask

  task automatic redirect(input logic [AW-1:0] a);
    do_redir = 1; do_addr = a;
    step();
    do_redir = 0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[0] = pack5(6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 2'b11);
    mem[1] = pack5(6'd2, 6'd0, 6'd9, 6'd9, 6'd9, 2'b00);
    mem[2] = longw(1'b1, 6'h05, 24'h00ABCD);
    mem[3] = pack5(6'd1, 6'd8, 6'd1, 6'd1, 6'd0, 2'b00);
    mem[4] = 32'hDEAD_0004;
    mem[5] = 32'h1234_5678;
    mem[6] = 32'hCAFE_0006;
    mem[7] = pack5(6'd1, 6'd0, 6'd0, 6'd0, 6'd0, 2'b00);
    mem[8] = 32'h8000_1234;
    mem[40] = pack5(6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 2'b00);
    mem[60] = pack5(6'd9, 6'd0, 6'd0, 6'd0, 6'd0, 2'b00);
    mem[70] = longw(1'b0, 6'h2A, 24'h000050);
    mem[71] = pack5(6'd11, 6'd0, 6'd0, 6'd0, 6'd0, 2'b00);
    mem[80] = pack5(6'd12, 6'd13, 6'd0, 6'd0, 6'd0, 2'b00);

    rst_n = 1'b0; redir_valid = 0; redir_addr = '0; do_addr = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; iss_ready = 0;
    repeat (3) @(negedge clk);
    check(!iss_valid, "R1", "iss_valid in reset", iss_valid, 0);
    check(mem_req_addr == '0, "R1", "reset fetch address", mem_req_addr, 0);
    fetch_q.push_back(24'd0);
    rst_n = 1'b1;

    tag = "R2"; // slot order, low bits ignored
    short_op(6'd3); short_op(6'd4); short_op(6'd5); short_op(6'd6); short_op(6'd7);
    fetch_q.push_back(24'd1);
    drain();
    tag = "R3"; // zero opcode ends the word
    short_op(6'd2); fetch_q.push_back(24'd2);
    drain();
    tag = "R4"; // long call, then sequential fetch
    exp_q.push_back('{lit: 0, lng: 1, call: 1, op: 6'h05, tgt: 24'h00ABCD, val: '0});
    fetch_q.push_back(24'd3);
    drain();
    tag = "R5"; // three literals with operands at 4, 5, 6
    fetch_q.push_back(24'd4); lit_op(32'hDEAD_0004); short_op(6'd8);
    fetch_q.push_back(24'd5); lit_op(32'h1234_5678);
    fetch_q.push_back(24'd6); lit_op(32'hCAFE_0006);
    drain();
    tag = "R6"; // resume at 3+1+3, then 7+1+1
    fetch_q.push_back(24'd7); fetch_q.push_back(24'd8); lit_op(32'h8000_1234);
    fetch_q.push_back(24'd9);
    drain();

    tag = "R7"; // redirect while slots remain
    redirect(24'd40);
    fetch_q.push_back(24'd40); short_op(6'd3); short_op(6'd4);
    drain();
    redirect(24'd60);
    fetch_q.push_back(24'd60); short_op(6'd9); fetch_q.push_back(24'd61);
    drain();

    tag = "R7"; // redirect while a sequential fetch is in flight
    redirect(24'd70);
    fetch_q.push_back(24'd70);
    exp_q.push_back('{lit: 0, lng: 1, call: 0, op: 6'h2A, tgt: 24'h000050, val: '0});
    fetch_q.push_back(24'd71);
    drain();
    redirect(24'd80);
    fetch_q.push_back(24'd80); short_op(6'd12); short_op(6'd13); fetch_q.push_back(24'd81);
    drain();
    repeat (4) step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule